// File: doc/BRIEF.md
# Monochrome Panel Display Memory with Column Counter

This block holds the pixel image for a 132-column by 65-row monochrome panel. The rows are split into eight full pages of eight rows each, plus a ninth page that holds one row of icon pixels. A host port reaches the memory one byte at a time. Each byte is one column of one page: bit 0 is the top row of that page and bit 7 the bottom row. A page register and a column counter address the host port. The column counter loads one nibble at a time and steps forward after every host access, so the host can stream a run of columns with no address traffic in between.

A second, independent read port serves the panel refresh logic. That port names a page and a segment number and receives the byte one cycle later. A segment-reversal input mirrors the segment-to-column relationship for panels that are mounted flipped. Host writes never stall or corrupt the refresh port.

The column counter stops at the last column and does not wrap. If the column is loaded with a value beyond the last column, the counter freezes and all host accesses are discarded until a new column value is loaded.

Top module: `lcd_dram`

## Requirements
- R1: After reset the page register is 0, the column counter is 0, and both `host_rdata` and `disp_data` are 0.
- R2: A host write stores `host_wdata` at the current page and column of a full page (0 to 7). A later host read of the same place returns the same byte. `host_rdata` is registered, valid from the cycle after the `host_rd` strobe, and held until the next strobe.
- R3: The page register changes only when `cmd_page_we` is high, and it then takes `cmd_page_val`. Host reads and writes leave it unchanged.
- R4: `cmd_colhi_we` loads `cmd_nib` into column bits 7:4 and `cmd_collo_we` loads it into bits 3:0. Each keeps the other nibble. A column load takes priority over the access step in the same cycle.
- R5: Each cycle with `host_rd` or `host_wr` high advances the column by one, after the access at the old column.
- R6: The column stops at 131 (0x83). An access at column 131 leaves the counter at 131.
- R7: A column of 132 (0x84) or above locks the counter. While it is locked the counter does not move, writes are discarded and reads return 0x00. The next column load clears the lock.
- R8: On page 8 only bit 0 is stored. A read there returns the stored bit in bit 0 and zeros in bits 7:1.
- R9: Page values 9 to 15 are out of range. Writes to them are discarded and reads from them return 0x00.
- R10: The display port returns, one cycle after `disp_page` and `disp_seg` are presented, the byte stored at that page and column. A host write to the same place in the same cycle yields the old byte on that read and the new byte on the next one.
- R11: With `seg_rev` low, segment n reads column n. With it high, segment n reads column 131−n. Segments above 131 and pages above 8 read 0x00, and host addressing is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_page_we | input | 1 | Load the page register |
| cmd_page_val | input | 4 | New page value |
| cmd_colhi_we | input | 1 | Load the column high nibble |
| cmd_collo_we | input | 1 | Load the column low nibble |
| cmd_nib | input | 4 | Nibble value for column loads |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe |
| host_rdata | output | 8 | Host read byte (registered) |
| seg_rev | input | 1 | Reverse segment-to-column mapping |
| disp_page | input | 4 | Display read page |
| disp_seg | input | 8 | Display read segment |
| disp_data | output | 8 | Display read byte (registered) |

## Verification
The hardest states to reach from the ports are the column counter's end states: saturation at column 131 and the lock above it. The column is not an output, so it can only be seen through the data that host accesses return. The stimulus loads columns just below the end and streams accesses across it. It also loads out-of-range columns through separate high and low nibble loads, then checks that writes were dropped by reloading a valid column and reading the earlier contents back. A same-cycle host write and display read of one cell checks the old-then-new order on the refresh port.

// File: rtl/lcd_dram_pkg.sv
package lcd_dram_pkg;
  localparam int COLS     = 132;
  localparam int FULL_PGS = 8;
  localparam int PW       = 4;
  localparam int CW       = 8;
  localparam int DW       = 8;
  localparam int IDXW     = $clog2(COLS * FULL_PGS);

  typedef logic [CW-1:0] col_t;
  typedef logic [PW-1:0] page_t;

  typedef enum logic [1:0] {PG_FULL, PG_ICON, PG_NONE} page_kind_e;

  localparam col_t LAST_COL = col_t'(COLS - 1);

  function automatic logic col_is_locked(col_t c);
    return c > LAST_COL;
  endfunction

  function automatic col_t col_after_access(col_t c);
    if (c < LAST_COL) return c + col_t'(1);
    return c;
  endfunction

  function automatic page_kind_e page_kind(page_t p);
    if (int'(p) < FULL_PGS) return PG_FULL;
    if (int'(p) == FULL_PGS) return PG_ICON;
    return PG_NONE;
  endfunction

  function automatic logic [IDXW-1:0] cell_index(page_t p, col_t c);
    return IDXW'(p) * IDXW'(COLS) + IDXW'(c);
  endfunction

  function automatic col_t seg_to_col(col_t s, logic rev);
    return rev ? (LAST_COL - s) : s;
  endfunction
endpackage

// File: rtl/lcd_page_reg.sv
module lcd_page_reg #(
  parameter int PW = lcd_dram_pkg::PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [PW-1:0] set_val,
  output logic [PW-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      page_q <= '0;
    else if (set_en) page_q <= set_val;
  end
endmodule

// File: rtl/lcd_col_ctr.sv
module lcd_col_ctr
  import lcd_dram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_hi,
  input  logic        set_lo,
  input  logic [CW/2-1:0] nib,
  input  logic        step,
  output col_t        col_q,
  output logic        locked
);
  localparam int HW = CW / 2;

  col_t col_loaded;

  always_comb begin
    col_loaded = col_q;
    if (set_hi) col_loaded[CW-1:HW] = nib;
    if (set_lo) col_loaded[HW-1:0]  = nib;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               col_q <= '0;
    else if (set_hi || set_lo) col_q <= col_loaded;
    else if (step)            col_q <= col_after_access(col_q);
  end

  assign locked = col_is_locked(col_q);
endmodule

// File: rtl/lcd_pixel_store.sv
module lcd_pixel_store
  import lcd_dram_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  page_t         wr_page,
  input  col_t          wr_col,
  input  logic [DW-1:0] wr_data,
  input  logic          ha_en,
  input  logic          ha_ok,
  input  page_t         ha_page,
  input  col_t          ha_col,
  output logic [DW-1:0] ha_data,
  input  page_t         db_page,
  input  col_t          db_col,
  input  logic          db_ok,
  output logic [DW-1:0] db_data
);
  localparam int CELLS = COLS * FULL_PGS;

  logic [DW-1:0] full_mem [CELLS];
  logic          icon_mem [COLS];

  function automatic logic [DW-1:0] fetch(page_t p, col_t c, logic ok);
    logic [DW-1:0] v;
    v = '0;
    if (ok && c <= LAST_COL) begin
      unique case (page_kind(p))
        PG_FULL: v = full_mem[cell_index(p, c)];
        PG_ICON: v = {{(DW-1){1'b0}}, icon_mem[c]};
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && wr_col <= LAST_COL) begin
      if (page_kind(wr_page) == PG_FULL)
        full_mem[cell_index(wr_page, wr_col)] <= wr_data;
      else if (page_kind(wr_page) == PG_ICON)
        icon_mem[wr_col] <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ha_data <= '0;
      db_data <= '0;
    end else begin
      if (ha_en) ha_data <= fetch(ha_page, ha_col, ha_ok);
      db_data <= fetch(db_page, db_col, db_ok);
    end
  end
endmodule

// File: rtl/lcd_dram.sv
module lcd_dram
  import lcd_dram_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_page_we,
  input  logic [3:0]    cmd_page_val,
  input  logic          cmd_colhi_we,
  input  logic          cmd_collo_we,
  input  logic [3:0]    cmd_nib,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  output logic [7:0]    host_rdata,
  input  logic          seg_rev,
  input  logic [3:0]    disp_page,
  input  logic [7:0]    disp_seg,
  output logic [7:0]    disp_data
);
  page_t page_q;
  col_t  col_q;
  logic  col_lock;
  logic  host_acc;
  logic  wr_fire;
  col_t  disp_col;
  logic  disp_ok;

  assign host_acc = host_rd || host_wr;
  assign wr_fire  = host_wr && !col_lock;
  assign disp_ok  = disp_seg <= LAST_COL;
  assign disp_col = seg_to_col(disp_seg, seg_rev);

  lcd_page_reg #(.PW(PW)) u_page (
    .clk(clk), .rst_n(rst_n), .set_en(cmd_page_we),
    .set_val(cmd_page_val), .page_q(page_q)
  );

  lcd_col_ctr u_col (
    .clk(clk), .rst_n(rst_n), .set_hi(cmd_colhi_we), .set_lo(cmd_collo_we),
    .nib(cmd_nib), .step(host_acc), .col_q(col_q), .locked(col_lock)
  );

  lcd_pixel_store u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_page(page_q), .wr_col(col_q), .wr_data(host_wdata),
    .ha_en(host_rd), .ha_ok(!col_lock), .ha_page(page_q), .ha_col(col_q),
    .ha_data(host_rdata),
    .db_page(disp_page), .db_col(disp_col), .db_ok(disp_ok), .db_data(disp_data)
  );
endmodule

// File: rtl/lcd_dram_chk.sv
module lcd_dram_chk
  import lcd_dram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_page_we,
  input logic       cmd_colhi_we,
  input logic       cmd_collo_we,
  input logic       host_rd,
  input logic       host_wr,
  input logic [3:0] page_q,
  input logic [7:0] col_q,
  input logic       col_lock,
  input logic [7:0] host_rdata,
  input logic [7:0] disp_seg,
  input logic [7:0] disp_data
);
  logic col_set;
  assign col_set = cmd_colhi_we || cmd_collo_we;

  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_page_we |=> $stable(page_q));

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) && !col_set && col_q < 8'd131 |=> col_q == $past(col_q) + 8'd1);

  p_col_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) && !col_set && col_q == 8'd131 |=> col_q == 8'd131);

  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_lock && !col_set |=> $stable(col_q) && col_lock);

  p_lock_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && col_lock |=> host_rdata == 8'd0);

  p_icon_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && page_q == 4'd8 |=> host_rdata[7:1] == 7'd0);

  p_bad_page_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && page_q > 4'd8 |=> host_rdata == 8'd0);

  p_disp_oob_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_seg > 8'd131 |=> disp_data == 8'd0);
endmodule

bind lcd_dram lcd_dram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_page_we(cmd_page_we),
  .cmd_colhi_we(cmd_colhi_we), .cmd_collo_we(cmd_collo_we),
  .host_rd(host_rd), .host_wr(host_wr), .page_q(page_q), .col_q(col_q),
  .col_lock(col_lock), .host_rdata(host_rdata), .disp_seg(disp_seg),
  .disp_data(disp_data)
);

// File: tb/lcd_dram_tb.sv
module lcd_dram_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_page_we = 1'b0;
  logic [3:0] cmd_page_val = '0;
  logic       cmd_colhi_we = 1'b0;
  logic       cmd_collo_we = 1'b0;
  logic [3:0] cmd_nib = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       seg_rev = 1'b0;
  logic [3:0] disp_page = '0;
  logic [7:0] disp_seg = '0;
  logic [7:0] disp_data;

  int checks = 0;
  int errors = 0;
  int pg = 0;
  int cl = 0;
  int mdl [9][132];

  always #4 clk = ~clk;

  lcd_dram u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_host_rd(int p, int c);
    if (c > 131 || p > 8) return 0;
    return mdl[p][c];
  endfunction

  function automatic int exp_disp(int p, int s, bit rev);
    int c;
    if (s > 131 || p > 8) return 0;
    c = rev ? 131 - s : s;
    return mdl[p][c];
  endfunction

  function automatic int next_col(int c);
    return (c < 131) ? c + 1 : c;
  endfunction

  task automatic set_page(int p);
    @(negedge clk); cmd_page_we = 1'b1; cmd_page_val = 4'(p);
    @(negedge clk); cmd_page_we = 1'b0;
    pg = p;
  endtask

  task automatic set_hi(int n);
    @(negedge clk); cmd_colhi_we = 1'b1; cmd_nib = 4'(n);
    @(negedge clk); cmd_colhi_we = 1'b0;
    cl = (n << 4) | (cl & 15);
  endtask

  task automatic set_lo(int n);
    @(negedge clk); cmd_collo_we = 1'b1; cmd_nib = 4'(n);
    @(negedge clk); cmd_collo_we = 1'b0;
    cl = (cl & 240) | n;
  endtask

  task automatic set_col(int c);
    set_hi(c >> 4);
    set_lo(c & 15);
  endtask

  task automatic host_write(int d);
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'(d);
    @(negedge clk); host_wr = 1'b0;
    if (cl <= 131 && pg <= 8) mdl[pg][cl] = (pg == 8) ? (d & 1) : (d & 255);
    cl = next_col(cl);
  endtask

  task automatic host_read(string req);
    int e;
    e = exp_host_rd(pg, cl);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk(req, int'(host_rdata), e);
    cl = next_col(cl);
  endtask

  task automatic disp_read(string req, int p, int s, bit rev);
    @(negedge clk); disp_page = 4'(p); disp_seg = 8'(s); seg_rev = rev;
    @(negedge clk);
    chk(req, int'(disp_data), exp_disp(p, s, rev));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 host_rdata", int'(host_rdata), 0);
    chk("R1 disp_data", int'(disp_data), 0);
    rst_n = 1'b1;
    void'($urandom(32'd1234));

    // R1: reset counters put this write at page 0, column 0
    host_write(8'hA5);
    set_col(0);
    host_read("R1 reset page0 col0");
    host_read("R5 step to col1 (unwritten->model)");

    // fill every page and column with random data
    for (int p = 0; p <= 8; p++) begin
      set_page(p);
      set_col(0);
      for (int c = 0; c < 132; c++) host_write(int'($urandom) & 255);
    end

    // R2 round trip over a stream
    set_page(3); set_col(10);
    for (int i = 0; i < 6; i++) host_read("R2 stream readback");
    set_col(40); host_write(8'h3C); set_col(40); host_read("R2 single readback");

    // R4 high nibble alone keeps low nibble
    set_page(5); set_col(8'h25); set_hi(4);
    host_read("R4 hi nibble only -> 0x45");
    set_lo(9);
    host_read("R4 lo nibble only -> 0x49");

    // R6 saturation at 131
    set_page(2); set_col(130);
    host_write(8'h11); host_write(8'h22); host_write(8'h33);
    set_col(129);
    for (int i = 0; i < 4; i++) host_read("R6 saturate at 131");

    // R7 lock
    set_page(1); set_col(8'h90);
    host_write(8'hEE);
    host_read("R7 locked read zero");
    set_col(8'h84); host_write(8'hEF); host_read("R7 locked at 0x84");
    set_col(8'h83); host_read("R7 unlock by reload");
    set_col(8'h10); host_read("R7 earlier write dropped");

    // R8 icon page
    set_page(8); set_col(3); host_write(8'hFF);
    set_col(3); host_read("R8 icon bit only");
    host_write(8'hFE); set_col(4); host_read("R8 icon bit0 clear");

    // R9 bad page
    set_page(12); set_col(7); host_write(8'h5A);
    set_col(7); host_read("R9 bad page read zero");
    set_page(4); set_col(7); host_read("R9 write dropped");
    set_page(9); set_col(0); host_read("R9 page 9 zero");

    // R3 page unchanged by accesses
    set_page(6); set_col(20);
    for (int i = 0; i < 3; i++) host_write(i + 7);
    set_col(20);
    for (int i = 0; i < 3; i++) host_read("R3 page held across accesses");

    // R11 mapping
    disp_read("R11 seg0 normal", 0, 0, 1'b0);
    disp_read("R11 seg0 reversed", 0, 0, 1'b1);
    disp_read("R11 seg131 reversed", 7, 131, 1'b1);
    disp_read("R11 seg over range", 3, 140, 1'b0);
    disp_read("R11 seg over range rev", 3, 200, 1'b1);
    disp_read("R11 page over range", 10, 5, 1'b0);
    disp_read("R11 icon page", 8, 3, 1'b0);

    // R10 concurrent write and display read of one cell
    set_page(2); set_col(50);
    begin
      int old_v;
      old_v = mdl[2][50];
      @(negedge clk);
      host_wr = 1'b1; host_wdata = 8'h96;
      disp_page = 4'd2; disp_seg = 8'd50; seg_rev = 1'b0;
      @(negedge clk);
      host_wr = 1'b0;
      chk("R10 same-cycle old value", int'(disp_data), old_v);
      mdl[2][50] = 8'h96; cl = next_col(cl);
      @(negedge clk);
      chk("R10 next-cycle new value", int'(disp_data), 8'h96);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0: set_page(int'($urandom % 10));
        1: set_col(int'($urandom % 140));
        2, 3, 4: host_write(int'($urandom) & 255);
        5, 6: host_read("R2 random read");
        default: disp_read("R10 random display", int'($urandom % 10),
                           int'($urandom % 136), 1'($urandom));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule